// File: doc/BRIEF.md
# Store-and-Forward Packet Buffer with Errored-Packet Discard

This block sits on the ingress side of a packet path. It receives packets beat by beat on a streaming sink. Each beat carries a 64-bit word, start and end markers, an empty count for the final beat and an error flag. The block holds every packet in full before it releases it. A packet that shows the error flag on any accepted beat never appears downstream. Packets that arrive clean leave on a plain valid/ready source with their framing unchanged.

The sink uses a ready latency of one. The block raises `in_ready` in one cycle, and a beat offered with `in_valid` in the next cycle is taken. Beats are written into a ring at a speculative write pointer. A second, committed pointer moves only when a clean end-of-packet beat is taken. A dropped packet rolls the speculative pointer back to the committed one. The read side can see only committed entries, so it never presents part of a packet.

Top module: `pkt_drop_buffer`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A beat is accepted at a clock edge only if `in_valid` is 1 in that cycle and `in_ready` was 1 in the cycle before. A beat offered while the previous cycle's `in_ready` was 0 has no effect.
- R3: `in_ready` is 1 exactly when at least two entries are free. Free means DEPTH minus every stored beat, counting beats of the packet still being received.
- R4: Every clean packet is forwarded in arrival order. Each beat keeps its data word, its start flag and its end flag.
- R5: On the end beat, `out_empty` equals `in_empty` with bit 0 cleared. Input values 0/1, 2/3, 4/5 and 6/7 mean 0, 2, 4 and 6 unused low-order bytes. On any other beat, `out_empty` is 0.
- R6: `out_valid` stays 0 until the end beat of a clean packet has been accepted. It becomes 1 in the cycle after that edge.
- R7: If any accepted beat of a packet has `in_err` = 1, the whole packet is discarded. Later beats are discarded up to and including its end beat.
- R8: A start beat accepted while a packet is still open discards the open partial packet. That start beat then begins a new packet.
- R9: An accepted beat without the start flag, arriving while no packet is open, is discarded.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output beat holds steady. The read side advances only on a cycle where both are 1.
- R11: A packet as long as DEPTH beats is stored and forwarded in full, even with the output stalled throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input beat qualifier |
| in_ready | output | 1 | Sink ready, latency one |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_data | input | DATA_W | Beat data word |
| in_empty | input | EMPTY_W | Unused bytes on the last beat, bit 0 ignored |
| in_err | input | 1 | Beat error flag |
| out_valid | output | 1 | Output beat qualifier |
| out_ready | input | 1 | Downstream ready, latency zero |
| out_sop | output | 1 | First beat of a forwarded packet |
| out_eop | output | 1 | Last beat of a forwarded packet |
| out_data | output | DATA_W | Forwarded data word |
| out_empty | output | EMPTY_W | Forwarded empty count |

## Verification
The bench builds the block with DEPTH = 8 and DATA_W = 64. The small depth lets one eight-beat packet fill the ring completely. This brings the two-entry ready threshold, the full-ring stall and the case of a beat held against a low ready into a short run. The full 64-bit width keeps every empty code, odd values included, reachable on the last beat.

// File: rtl/pkt_drop_pkg.sv
package pkt_drop_pkg;
  // Ingress packet tracking
  typedef enum logic [1:0] {
    ING_IDLE    = 2'd0,
    ING_STORE   = 2'd1,
    ING_DISCARD = 2'd2
  } ing_state_e;
endpackage

// File: rtl/pkt_store.sv
module pkt_store #(
  parameter int WIDTH = 69,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/pkt_ingress_ctl.sv
module pkt_ingress_ctl
  import pkt_drop_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic        in_err,
  output logic        in_ready,
  input  logic [PW:0] rd_ptr,
  output logic [PW:0] com_ptr,
  output logic        wr_en,
  output logic [PW-1:0] wr_addr
);
  localparam logic [PW:0] DEPTH_P   = (PW+1)'(DEPTH);
  localparam logic [PW:0] READY_MAX = DEPTH_P - (PW+1)'(2);

  ing_state_e  st_q, st_d;
  logic [PW:0] spec_q, spec_d, com_q, com_d, base, used;
  logic        rdy_q, accept;

  assign used     = spec_q - rd_ptr;
  assign in_ready = (used <= READY_MAX);
  assign accept   = in_valid & rdy_q;
  assign base     = in_sop ? com_q : spec_q;
  assign wr_addr  = base[PW-1:0];
  assign com_ptr  = com_q;

  always_comb begin
    st_d   = st_q;
    spec_d = spec_q;
    com_d  = com_q;
    wr_en  = 1'b0;
    if (accept) begin
      if (in_err) begin
        spec_d = com_q;
        st_d   = in_eop ? ING_IDLE : ING_DISCARD;
      end else if (!in_sop && st_q != ING_STORE) begin
        if (in_eop) st_d = ING_IDLE;
      end else begin
        wr_en  = 1'b1;
        spec_d = base + (PW+1)'(1);
        if (in_eop) begin
          com_d = base + (PW+1)'(1);
          st_d  = ING_IDLE;
        end else begin
          st_d  = ING_STORE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      st_q   <= ING_IDLE;
      spec_q <= '0;
      com_q  <= '0;
    end else begin
      rdy_q <= in_ready;
      if (accept) begin
        st_q   <= st_d;
        spec_q <= spec_d;
        com_q  <= com_d;
      end
    end
  end

  // R3: occupancy never exceeds the ring
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    used <= DEPTH_P);
  // R2: no write unless ready was seen in the previous cycle
  a_r2_latency_one: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !$past(in_ready)) |-> !wr_en);
  // R7: an errored beat leaves no uncommitted beats behind
  a_r7_rollback: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_err) |=> (spec_q == com_q));
  // R6: committed region lies within the stored region
  a_r6_commit_inside: assert property (@(posedge clk) disable iff (!rst_n)
    (com_q - rd_ptr) <= used);
endmodule

// File: rtl/pkt_egress.sv
module pkt_egress #(
  parameter int DEPTH = 64,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [PW:0] com_ptr,
  input  logic        ent_sop,
  input  logic        ent_eop,
  input  logic        out_ready,
  output logic        out_valid,
  output logic [PW:0] rd_ptr
);
  logic [PW:0] rd_q, rd_d;
  logic        mid_q, mid_d, take;

  assign out_valid = (com_ptr != rd_q);
  assign take      = out_valid & out_ready;
  assign rd_ptr    = rd_q;

  always_comb begin
    rd_d  = rd_q + (PW+1)'(1);
    mid_d = ~ent_eop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      mid_q <= 1'b0;
    end else if (take) begin
      rd_q  <= rd_d;
      mid_q <= mid_d;
    end
  end

  // R10: a stalled beat keeps its slot
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && rd_q == $past(rd_q)));
  // R4: start flag appears exactly at packet boundaries
  a_r4_framing: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ent_sop == !mid_q));
endmodule

// File: rtl/pkt_drop_buffer.sv
module pkt_drop_buffer #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 64,
  localparam int EMPTY_W = $clog2(DATA_W/8),
  localparam int PW      = $clog2(DEPTH),
  localparam int ENT_W   = DATA_W + EMPTY_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic [DATA_W-1:0]  in_data,
  input  logic [EMPTY_W-1:0] in_empty,
  input  logic               in_err,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_sop,
  output logic               out_eop,
  output logic [DATA_W-1:0]  out_data,
  output logic [EMPTY_W-1:0] out_empty
);
  logic [1:0]         rst_pipe_q;
  logic               rst_ni;
  logic [PW:0]        rd_ptr, com_ptr;
  logic               wr_en;
  logic [PW-1:0]      wr_addr;
  logic [EMPTY_W-1:0] wr_empty;
  logic [ENT_W-1:0]   wr_ent, rd_ent;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  assign wr_empty = in_eop ? (in_empty & ~EMPTY_W'(1)) : '0;
  assign wr_ent   = {in_sop, in_eop, wr_empty, in_data};

  pkt_ingress_ctl #(.DEPTH(DEPTH)) u_ing (
    .clk(clk), .rst_n(rst_ni),
    .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_err(in_err),
    .in_ready(in_ready), .rd_ptr(rd_ptr), .com_ptr(com_ptr),
    .wr_en(wr_en), .wr_addr(wr_addr)
  );

  pkt_store #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_ent),
    .rd_addr(rd_ptr[PW-1:0]), .rd_data(rd_ent)
  );

  pkt_egress #(.DEPTH(DEPTH)) u_egr (
    .clk(clk), .rst_n(rst_ni), .com_ptr(com_ptr),
    .ent_sop(rd_ent[ENT_W-1]), .ent_eop(rd_ent[ENT_W-2]),
    .out_ready(out_ready), .out_valid(out_valid), .rd_ptr(rd_ptr)
  );

  assign out_sop   = rd_ent[ENT_W-1];
  assign out_eop   = rd_ent[ENT_W-2];
  assign out_empty = rd_ent[DATA_W +: EMPTY_W];
  assign out_data  = rd_ent[DATA_W-1:0];

  // R10: stalled output content is steady
  a_r10_data_stable: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && !out_ready) |=> ($stable(out_data) && $stable(out_empty)
                                   && $stable(out_eop)));
  // R5: empty is even and only set on an end beat
  a_r5_empty_even: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> (!out_empty[0] && (out_eop || out_empty == '0)));
endmodule

// File: tb/test_pkt_drop_buffer.sv
module test_pkt_drop_buffer;
  localparam int DW = 64;
  localparam int EW = 3;
  localparam int DEPTH = 8;
  localparam int BW = DW + EW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_err = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [EW-1:0] in_empty = '0;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_sop, out_eop;
  logic [DW-1:0] out_data;
  logic [EW-1:0] out_empty;

  always #4 clk = ~clk;

  pkt_drop_buffer #(.DATA_W(DW), .DEPTH(DEPTH)) i_pkt_drop_buffer (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .in_empty(in_empty), .in_err(in_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
    .out_eop(out_eop), .out_data(out_data), .out_empty(out_empty)
  );

  int total = 0;
  int bad = 0;
  string scen = "R1";
  logic [BW-1:0] q_com[$];
  logic [BW-1:0] q_part[$];
  int mst = 0;       // 0 idle, 1 in packet, 2 discarding
  bit prev_rdy = 1'b0;
  int omode = 0;     // 0 always ready, 1 random, 2 stalled
  bit done = 1'b0;

  task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s (%s): actual=%h expected=%h", tag, scen, act, exp);
    end
  endtask

  // one clock: compare, then advance the model as the next edge will
  task automatic cycle(output bit acc);
    bit er, ev;
    logic [BW-1:0] b;
    case (omode)
      0: out_ready = 1'b1;
      1: out_ready = ($urandom % 2) == 0;
      default: out_ready = 1'b0;
    endcase
    er = (DEPTH - (q_com.size() + q_part.size())) >= 2;
    ev = q_com.size() > 0;
    check("R3", 80'(in_ready), 80'(er));
    check("R6", 80'(out_valid), 80'(ev));
    if (ev) begin
      check("R4", 80'({out_sop, out_eop, out_data}),
            80'({q_com[0][BW-1], q_com[0][BW-2], q_com[0][DW-1:0]}));
      check("R5", 80'(out_empty), 80'(q_com[0][DW +: EW]));
    end
    acc = in_valid && prev_rdy;
    if (ev && out_ready) void'(q_com.pop_front());
    if (acc) begin
      b = {in_sop, in_eop, (in_eop ? (in_empty & 3'b110) : 3'b000), in_data};
      if (in_err) begin
        q_part.delete();
        mst = in_eop ? 0 : 2;
      end else if (!in_sop && mst != 1) begin
        if (in_eop) mst = 0;
      end else begin
        if (in_sop) q_part.delete();
        q_part.push_back(b);
        if (in_eop) begin
          foreach (q_part[k]) q_com.push_back(q_part[k]);
          q_part.delete();
          mst = 0;
        end else begin
          mst = 1;
        end
      end
    end
    prev_rdy = er;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    bit a;
    in_valid = 1'b0;
    repeat (n) cycle(a);
  endtask

  task automatic send_beat(input bit s, input bit e, input logic [2:0] emp,
                           input bit er, input bit gaps);
    bit a;
    int tries = 0;
    if (gaps && ($urandom % 3) == 0) idle(1);
    in_sop = s; in_eop = e; in_empty = emp; in_err = er;
    in_data = {$urandom, $urandom};
    in_valid = 1'b1;
    do begin
      cycle(a);
      tries++;
      if (tries == 6 && omode == 2) omode = 0;
    end while (!a);
    in_valid = 1'b0;
  endtask

  task automatic send_pkt(input int len, input int err_at, input logic [2:0] emp,
                          input bit gaps);
    for (int i = 0; i < len; i++)
      send_beat(i == 0, i == len - 1, emp, i == err_at, gaps);
  endtask

  task automatic drain();
    omode = 0;
    idle(2);
    while (q_com.size() > 0) idle(1);
    idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    scen = "R1";
    check("R1", 80'(in_ready), 80'(1));
    check("R1", 80'(out_valid), 80'(0));
    rst_n = 1'b1;
    idle(4);

    // R4 R5 R6: clean packets, every empty code
    scen = "R4 clean";
    for (int e = 0; e < 8; e++) send_pkt(1 + (e % 4), -1, 3'(e), 1'b0);
    drain();

    // R10: random output stalls with input gaps
    scen = "R10 stall";
    omode = 1;
    for (int p = 0; p < 12; p++) send_pkt(1 + (p % 5), -1, 3'(p), 1'b1);
    drain();

    // R7: errors at first, middle, last beat; single-beat errored packet
    scen = "R7 drop";
    send_pkt(4, 0, 3'd2, 1'b0);
    send_pkt(4, 2, 3'd4, 1'b0);
    send_pkt(3, 2, 3'd6, 1'b0);
    send_pkt(1, 0, 3'd0, 1'b0);
    send_pkt(2, -1, 3'd3, 1'b0);
    drain();

    // R8: new start in the middle of an open packet
    scen = "R8 restart";
    send_beat(1'b1, 1'b0, 3'd0, 1'b0, 1'b0);
    send_beat(1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
    send_pkt(3, -1, 3'd5, 1'b0);
    drain();

    // R9: beats without start while idle
    scen = "R9 stray";
    send_beat(1'b0, 1'b0, 3'd0, 1'b0, 1'b0);
    send_beat(1'b0, 1'b1, 3'd2, 1'b0, 1'b0);
    send_pkt(2, -1, 3'd1, 1'b0);
    drain();

    // R11 R3 R2: full-depth packet against a stalled output, then a held beat
    scen = "R11 full";
    omode = 2;
    send_pkt(DEPTH, -1, 3'd6, 1'b0);
    idle(2);
    scen = "R2 held";
    omode = 2;
    send_pkt(2, -1, 3'd4, 1'b0);
    drain();

    // R2: mixed traffic with random stalls
    scen = "R2 mix";
    omode = 1;
    for (int p = 0; p < 10; p++) send_pkt(1 + (p % 7), (p % 3 == 1) ? 1 : -1, 3'(p), 1'b1);
    drain();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule